// File: doc/BRIEF.md
# JTAG Master Scan Sequencer

This block is a JTAG master for a chain of one or more test access ports. It
divides the system clock down to TCK, drives TMS and TDI, and samples TDO. It
can walk the chain to the Test-Logic-Reset state and park it in Run-Test/Idle,
shift an instruction scan, or shift a series of data scans. All shift data comes
from an internal byte memory, and each bit returned on TDO is written back over
the bit it replaced.

A host first fills the memory through a simple byte port. It then picks an
operation, a scan length in bits and a repeat count, and pulses start. For a
data scan the repeat count makes the sequencer run that many scans back to back.
Each scan reads its bits from the next run of memory bytes. This lets a chain of
devices be fed a stream of words with a single start. The ready output is low
for the whole operation and goes high again once the chain is back in
Run-Test/Idle.

Top module: `jtag_scan_master`

## Requirements
- R1: After reset, ready is 1 and tck, tms and tdi are 0.
- R2: TCK has a period of TCK_DIV system clocks, with equal high and low halves, and it stays low while ready is 1. An operation of T TCK cycles holds ready low for exactly T*TCK_DIV system clocks.
- R3: Command 2'b00 (TAP reset) gives five TCK cycles with TMS at 1 and then one with TMS at 0, for six cycles in total. The chain ends in Run-Test/Idle whatever state it started in.
- R4: Command 2'b01 (instruction scan) of N bits gives the TMS sequence 1,1,0,0, then N shift cycles, then 1,0, for N+6 TCK cycles in total. It runs exactly one scan whatever the repeat count is.
- R5: Command 2'b10 (data scan) of N bits with repeat count W runs W scans back to back. Each scan gives TMS 1,0,0, then N shift cycles, then 1,0, for W*(N+5) TCK cycles in total, and ends in Run-Test/Idle.
- R6: In scan w (counting from 0), shift bit i is taken from memory byte w*ceil(N/8)+floor(i/8), at bit position i mod 8 (LSB first). The TDO bit sampled for shift i is stored at the same position. The unused high bits of the last byte of a scan are written as 0.
- R7: TMS is 0 during every shift cycle except the last, where it is 1. TMS and TDI change only when TCK falls, and TDO is sampled when TCK rises. TDI is 0 outside shift cycles.
- R8: ready falls only on an accepted start and rises only once the last scan has returned to Run-Test/Idle. While ready is 1, tms and tdi are 0.
- R9: A start received while ready is 0 is ignored, so the running operation keeps its length and content.
- R10: No TCK cycle is produced and ready stays 1 for any of these starts: a scan command with a length of 0, a data scan with a repeat count of 0, or command 2'b11.
- R11: A host write while ready is 0 is ignored. A host read returns the addressed byte one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start strobe, taken only while ready is 1 |
| cmd | input | 2 | 00 TAP reset, 01 instruction scan, 10 data scan, 11 none |
| scan_bits | input | SIZE_W | Scan length N in bits |
| scan_words | input | WC_W | Number of data scans per start |
| ready | output | 1 | High when no operation is running |
| host_we | input | 1 | Host byte write enable |
| host_addr | input | log2(MEM_BYTES) | Host byte address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, one clock after the address |
| tck | output | 1 | Test clock |
| tms | output | 1 | Test mode select |
| tdi | output | 1 | Test data to the chain |
| tdo | input | 1 | Test data from the chain |

## Verification
The bench connects a behavioural TAP with a 24-bit data register and a 4-bit
instruction register, each loaded with a fixed pattern at Capture. The returned
memory image and the value latched at Update therefore show the capture pattern
shifted out first and the programmed bits following it. Random data scans range
from 1 to 40 bits and 1 to 4 words. The lengths 1, 8, 9 and 24 are run on
purpose: they cover a one-bit scan, a scan that ends exactly on a byte, a scan
that spills one bit into a new byte, and a scan that exactly fills the target
register. Directed cases cover the TAP reset from Shift-DR, an instruction scan
with a repeat count larger than one, empty starts, and a start and a host write
that both arrive in the middle of a scan.

// File: rtl/jtag_scan_pkg.sv
`timescale 1ns/1ps
package jtag_scan_pkg;

  typedef enum logic [1:0] {
    CMD_TAP_RESET = 2'b00,
    CMD_IR_SCAN   = 2'b01,
    CMD_DR_SCAN   = 2'b10,
    CMD_NONE      = 2'b11
  } scan_cmd_e;

  // one entry per TCK cycle kind driven by the sequencer
  typedef enum logic [3:0] {
    SQ_IDLE,
    SQ_RST,
    SQ_SEL_DR,
    SQ_SEL_IR,
    SQ_CAPTURE,
    SQ_TO_SHIFT,
    SQ_SHIFT,
    SQ_UPDATE,
    SQ_RETURN
  } seq_state_e;

  localparam int RESET_TMS_HIGH = 5;

endpackage

// File: rtl/jtag_tck_gen.sv
`timescale 1ns/1ps
// TCK divider: emits one-cycle strobes on the system clock edge where TCK rises or falls.
module jtag_tck_gen #(
  parameter int TCK_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tck,
  output logic rise_evt,
  output logic fall_evt
);
  localparam int HALF = (TCK_DIV < 4) ? 2 : TCK_DIV / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt;
  logic          expire;

  assign expire   = run && (cnt == CNT_LAST);
  assign rise_evt = expire && !tck;
  assign fall_evt = expire && tck;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      tck <= 1'b0;
    end else if (expire) begin
      cnt <= '0;
      tck <= !tck;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/jtag_scan_ram.sv
`timescale 1ns/1ps
// Simple dual-port byte memory with registered read, block RAM friendly.
module jtag_scan_ram #(
  parameter int DEPTH = 256,
  parameter int AW    = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/jtag_scan_seq.sv
`timescale 1ns/1ps
// TMS/TDI sequencer, bit and word counters, memory addressing.
module jtag_scan_seq
  import jtag_scan_pkg::*;
#(
  parameter int SIZE_W = 16,
  parameter int WC_W   = 8,
  parameter int AW     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [1:0]        cmd,
  input  logic [SIZE_W-1:0] scan_bits,
  input  logic [WC_W-1:0]   scan_words,
  input  logic              rise_evt,
  input  logic              fall_evt,
  input  logic              tdo,
  input  logic [7:0]        rd_byte,
  output logic              ready,
  output logic              run,
  output logic              tms,
  output logic              tdi,
  output logic              wr_en,
  output logic [AW-1:0]     wr_addr,
  output logic [7:0]        wr_data,
  output logic [AW-1:0]     rd_addr
);
  localparam logic [2:0] RST_LAST = 3'(RESET_TMS_HIGH);

  scan_cmd_e         cmd_e;
  seq_state_e        state, st_n;
  logic [2:0]        rst_cnt, rc_n;
  logic              is_ir;
  logic [SIZE_W-1:0] bits_q, bit_idx, bit_n;
  logic [WC_W-1:0]   words_left, wl_n;
  logic [AW-1:0]     byte_addr;
  logic [7:0]        rx_byte, rx_merged;
  logic              launch_ok, last_bit, last_n, tms_n;

  assign cmd_e   = scan_cmd_e'(cmd);
  assign rd_addr = byte_addr;

  assign launch_ok = start && ready &&
                     ((cmd_e == CMD_TAP_RESET) ||
                      (cmd_e == CMD_IR_SCAN && scan_bits != '0) ||
                      (cmd_e == CMD_DR_SCAN && scan_bits != '0 && scan_words != '0));

  assign last_bit  = (bit_idx == bits_q - 1'b1);
  assign last_n    = (bit_n == bits_q - 1'b1);
  assign rx_merged = rx_byte | (8'(tdo) << bit_idx[2:0]);

  function automatic logic tms_for(seq_state_e s, logic [2:0] rc, logic lastb);
    case (s)
      SQ_RST:                return rc < RST_LAST;
      SQ_SEL_DR, SQ_SEL_IR:  return 1'b1;
      SQ_SHIFT:              return lastb;
      SQ_UPDATE:             return 1'b1;
      default:               return 1'b0;
    endcase
  endfunction

  // step taken at each falling TCK edge
  always_comb begin
    st_n = state;
    rc_n = rst_cnt;
    bit_n = bit_idx;
    wl_n = words_left;
    case (state)
      SQ_RST: begin
        if (rst_cnt == RST_LAST) st_n = SQ_IDLE;
        else rc_n = rst_cnt + 1'b1;
      end
      SQ_SEL_DR:   st_n = is_ir ? SQ_SEL_IR : SQ_CAPTURE;
      SQ_SEL_IR:   st_n = SQ_CAPTURE;
      SQ_CAPTURE:  st_n = SQ_TO_SHIFT;
      SQ_TO_SHIFT: begin
        st_n  = SQ_SHIFT;
        bit_n = '0;
      end
      SQ_SHIFT: begin
        if (last_bit) st_n = SQ_UPDATE;
        else bit_n = bit_idx + 1'b1;
      end
      SQ_UPDATE:   st_n = SQ_RETURN;
      SQ_RETURN: begin
        if (words_left > WC_W'(1)) begin
          st_n = SQ_SEL_DR;
          wl_n = words_left - 1'b1;
        end else begin
          st_n = SQ_IDLE;
        end
      end
      default:     st_n = SQ_IDLE;
    endcase
    tms_n = tms_for(st_n, rc_n, last_n);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= SQ_IDLE;
      ready      <= 1'b1;
      run        <= 1'b0;
      tms        <= 1'b0;
      tdi        <= 1'b0;
      wr_en      <= 1'b0;
      wr_addr    <= '0;
      wr_data    <= '0;
      rst_cnt    <= '0;
      is_ir      <= 1'b0;
      bits_q     <= '0;
      bit_idx    <= '0;
      words_left <= '0;
      byte_addr  <= '0;
      rx_byte    <= '0;
    end else begin
      wr_en <= 1'b0;
      if (state == SQ_IDLE) begin
        if (launch_ok) begin
          ready      <= 1'b0;
          run        <= 1'b1;
          tms        <= 1'b1;
          tdi        <= 1'b0;
          rst_cnt    <= '0;
          bit_idx    <= '0;
          byte_addr  <= '0;
          rx_byte    <= '0;
          bits_q     <= scan_bits;
          is_ir      <= (cmd_e == CMD_IR_SCAN);
          words_left <= (cmd_e == CMD_DR_SCAN) ? scan_words : WC_W'(1);
          state      <= (cmd_e == CMD_TAP_RESET) ? SQ_RST : SQ_SEL_DR;
        end
      end else begin
        if (rise_evt && state == SQ_SHIFT) begin
          if (bit_idx[2:0] == 3'd7 || last_bit) begin
            wr_en     <= 1'b1;
            wr_addr   <= byte_addr;
            wr_data   <= rx_merged;
            byte_addr <= byte_addr + 1'b1;
            rx_byte   <= '0;
          end else begin
            rx_byte   <= rx_merged;
          end
        end
        if (fall_evt) begin
          state      <= st_n;
          rst_cnt    <= rc_n;
          bit_idx    <= bit_n;
          words_left <= wl_n;
          tms        <= tms_n;
          tdi        <= (st_n == SQ_SHIFT) ? rd_byte[bit_n[2:0]] : 1'b0;
          if (st_n == SQ_IDLE) begin
            run   <= 1'b0;
            ready <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/jtag_scan_master.sv
`timescale 1ns/1ps
module jtag_scan_master #(
  parameter int TCK_DIV   = 4,
  parameter int SIZE_W    = 16,
  parameter int WC_W      = 8,
  parameter int MEM_BYTES = 256,
  localparam int AW       = $clog2(MEM_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [1:0]        cmd,
  input  logic [SIZE_W-1:0] scan_bits,
  input  logic [WC_W-1:0]   scan_words,
  output logic              ready,
  input  logic              host_we,
  input  logic [AW-1:0]     host_addr,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  output logic              tck,
  output logic              tms,
  output logic              tdi,
  input  logic              tdo
);
  logic          run, rise_evt, fall_evt;
  logic          eng_we;
  logic [AW-1:0] eng_waddr, eng_raddr;
  logic [7:0]    eng_wdata;
  logic          ram_we;
  logic [AW-1:0] ram_waddr, ram_raddr;
  logic [7:0]    ram_wdata, ram_rdata;

  jtag_tck_gen #(.TCK_DIV(TCK_DIV)) u_tck (
    .clk(clk), .rst(rst), .run(run),
    .tck(tck), .rise_evt(rise_evt), .fall_evt(fall_evt)
  );

  jtag_scan_seq #(.SIZE_W(SIZE_W), .WC_W(WC_W), .AW(AW)) u_seq (
    .clk(clk), .rst(rst), .start(start), .cmd(cmd),
    .scan_bits(scan_bits), .scan_words(scan_words),
    .rise_evt(rise_evt), .fall_evt(fall_evt), .tdo(tdo), .rd_byte(ram_rdata),
    .ready(ready), .run(run), .tms(tms), .tdi(tdi),
    .wr_en(eng_we), .wr_addr(eng_waddr), .wr_data(eng_wdata), .rd_addr(eng_raddr)
  );

  // host owns the memory ports only while idle
  assign ram_we    = ready ? host_we    : eng_we;
  assign ram_waddr = ready ? host_addr  : eng_waddr;
  assign ram_wdata = ready ? host_wdata : eng_wdata;
  assign ram_raddr = ready ? host_addr  : eng_raddr;
  assign host_rdata = ram_rdata;

  jtag_scan_ram #(.DEPTH(MEM_BYTES), .AW(AW)) u_ram (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .raddr(ram_raddr), .rdata(ram_rdata)
  );
endmodule

// File: rtl/jtag_scan_master_chk.sv
`timescale 1ns/1ps
module jtag_scan_master_chk #(
  parameter int SIZE_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic [1:0]        cmd,
  input logic [SIZE_W-1:0] scan_bits,
  input logic              ready,
  input logic              tck,
  input logic              tms,
  input logic              tdi,
  input logic              eng_we,
  input logic              ram_we
);
  assert_tck_low_idle_R2: assert property (@(posedge clk) disable iff (rst)
    ready |-> !tck);

  assert_tck_high_two_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(tck) |=> tck);

  assert_pins_hold_R7: assert property (@(posedge clk) disable iff (rst)
    tck |-> ($stable(tms) && $stable(tdi)));

  assert_idle_parked_R8: assert property (@(posedge clk) disable iff (rst)
    ready |-> (!tms && !tdi));

  assert_busy_needs_start_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(ready) |-> $past(start));

  assert_empty_start_R10: assert property (@(posedge clk) disable iff (rst)
    (ready && start && (cmd == 2'b11 || (cmd != 2'b00 && scan_bits == '0))) |=> ready);

  assert_host_blocked_R11: assert property (@(posedge clk) disable iff (rst)
    (!ready && !eng_we) |-> !ram_we);
endmodule

bind jtag_scan_master jtag_scan_master_chk #(.SIZE_W(SIZE_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .cmd(cmd), .scan_bits(scan_bits),
  .ready(ready), .tck(tck), .tms(tms), .tdi(tdi),
  .eng_we(eng_we), .ram_we(ram_we)
);

// File: tb/jtag_scan_master_bench.sv
`timescale 1ns/1ps
module jtag_scan_master_bench;
  localparam int DIV = 4;
  localparam int DR_LEN = 24;
  localparam logic [23:0] DR_CAP = 24'hC3A51E;
  localparam logic [3:0]  IR_CAP = 4'b0101;
  localparam int TLR=0, RTI=1, SDS=2, CDR=3, SDR=4, E1D=5, PDR=6, E2D=7, UDR=8,
                 SIS=9, CIR=10, SIR=11, E1I=12, PIR=13, E2I=14, UIR=15;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [1:0]  cmd = 2'b00;
  logic [15:0] scan_bits = '0;
  logic [7:0]  scan_words = '0;
  logic host_we = 1'b0;
  logic [7:0] host_addr = '0, host_wdata = '0;
  logic [7:0] host_rdata;
  logic ready, tck, tms, tdi;
  logic tdo = 1'b0;

  always #2 clk = ~clk;

  jtag_scan_master #(.TCK_DIV(DIV)) u_jtag_scan_master (
    .clk(clk), .rst(rst), .start(start), .cmd(cmd), .scan_bits(scan_bits),
    .scan_words(scan_words), .ready(ready), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .tck(tck), .tms(tms),
    .tdi(tdi), .tdo(tdo)
  );

  // behavioural TAP target
  int tap_st = SDR;
  int tck_cnt = 0, upd_dr_cnt = 0, upd_ir_cnt = 0;
  logic [23:0] dr_reg = '0, dr_upd = '0;
  logic [3:0]  ir_reg = '0, ir_upd = '0;

  function automatic int tap_next(int s, logic m);
    case (s)
      TLR: return m ? TLR : RTI;
      RTI: return m ? SDS : RTI;
      SDS: return m ? SIS : CDR;
      CDR: return m ? E1D : SDR;
      SDR: return m ? E1D : SDR;
      E1D: return m ? UDR : PDR;
      PDR: return m ? E2D : PDR;
      E2D: return m ? UDR : SDR;
      UDR: return m ? SDS : RTI;
      SIS: return m ? TLR : CIR;
      CIR: return m ? E1I : SIR;
      SIR: return m ? E1I : SIR;
      E1I: return m ? UIR : PIR;
      PIR: return m ? E2I : PIR;
      E2I: return m ? UIR : SIR;
      UIR: return m ? SDS : RTI;
      default: return TLR;
    endcase
  endfunction

  always @(posedge tck) begin
    tck_cnt <= tck_cnt + 1;
    case (tap_st)
      CDR: dr_reg <= DR_CAP;
      SDR: dr_reg <= {tdi, dr_reg[23:1]};
      UDR: begin dr_upd <= dr_reg; upd_dr_cnt <= upd_dr_cnt + 1; end
      CIR: ir_reg <= IR_CAP;
      SIR: ir_reg <= {tdi, ir_reg[3:1]};
      UIR: begin ir_upd <= ir_reg; upd_ir_cnt <= upd_ir_cnt + 1; end
      default: ;
    endcase
    tap_st <= tap_next(tap_st, tms);
  end

  always @(negedge tck)
    tdo <= (tap_st == SDR) ? dr_reg[0] : (tap_st == SIR) ? ir_reg[0] : 1'b0;

  int busy_cyc = 0;
  always @(posedge clk) if (ready === 1'b0) busy_cyc <= busy_cyc + 1;

  logic [7:0] img [256];
  int nchk = 0, nerr = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic host_write(input int a, input logic [7:0] v);
    host_we = 1'b1; host_addr = 8'(a); host_wdata = v;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic host_read(input int a, output logic [7:0] v);
    host_addr = 8'(a);
    @(negedge clk);
    v = host_rdata;
  endtask

  task automatic wait_ready();
    int g = 0;
    while (ready !== 1'b1 && g < 20000) begin @(negedge clk); g++; end
    if (ready !== 1'b1) check(1'b0, "R8", "watchdog expired", 0, 1);
  endtask

  task automatic launch(input logic [1:0] c, input int n, input int w);
    cmd = c; scan_bits = 16'(n); scan_words = 8'(w); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // combined stream seen on TDO: capture bits first, then programmed bits
  function automatic logic sbit(int base, int x);
    if (x < DR_LEN) return DR_CAP[x];
    return img[base + (x - DR_LEN) / 8][(x - DR_LEN) % 8];
  endfunction

  function automatic logic [7:0] exp_byte(int base, int n, int k);
    logic [7:0] r = '0;
    for (int b = 0; b < 8; b++) if (k * 8 + b < n) r[b] = sbit(base, k * 8 + b);
    return r;
  endfunction

  function automatic logic [23:0] exp_upd(int base, int n);
    logic [23:0] r;
    for (int j = 0; j < DR_LEN; j++) r[j] = sbit(base, n + j);
    return r;
  endfunction

  task automatic run_dr(input int n, input int w);
    int nb = (n + 7) / 8;
    int t0, u0, bad = 0;
    logic [7:0] v, e;
    for (int i = 0; i < nb * w; i++) begin
      img[i] = 8'($urandom);
      host_write(i, img[i]);
    end
    t0 = tck_cnt; u0 = upd_dr_cnt; busy_cyc = 0;
    launch(2'b10, n, w);
    wait_ready();
    check(tck_cnt - t0 == w * (n + 5), "R5", $sformatf("tck cycles n=%0d w=%0d", n, w),
          tck_cnt - t0, w * (n + 5));
    check(busy_cyc == w * (n + 5) * DIV, "R2", "busy clocks", busy_cyc, w * (n + 5) * DIV);
    check(tap_st == RTI && upd_dr_cnt - u0 == w, "R5", "idle and update count",
          upd_dr_cnt - u0, w);
    check(dr_upd == exp_upd((w - 1) * nb, n), "R7", "value at update",
          dr_upd, exp_upd((w - 1) * nb, n));
    for (int i = 0; i < nb * w; i++) begin
      host_read(i, v);
      e = exp_byte((i / nb) * nb, n, i % nb);
      if (v !== e) begin
        if (bad == 0) $display("FAIL R6 byte %0d n=%0d: actual %0h expected %0h", i, n, v, e);
        bad++;
      end
    end
    nchk++;
    if (bad != 0) nerr++;
  endtask

  initial begin
    logic [7:0] v;
    int t0, u0;
    void'($urandom(32'd7310));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(ready === 1'b1 && tck === 1'b0 && tms === 1'b0 && tdi === 1'b0, "R1",
          "reset state", {ready, tck, tms, tdi}, 4'b1000);

    // R3: TAP reset starting from Shift-DR
    t0 = tck_cnt; busy_cyc = 0;
    launch(2'b00, 0, 0);
    wait_ready();
    check(tck_cnt - t0 == 6, "R3", "reset tck cycles", tck_cnt - t0, 6);
    check(tap_st == RTI, "R3", "state after reset", tap_st, RTI);
    check(busy_cyc == 6 * DIV, "R2", "reset busy clocks", busy_cyc, 6 * DIV);

    // R4: instruction scan, repeat count ignored
    host_write(0, 8'h08);
    t0 = tck_cnt; u0 = upd_ir_cnt;
    launch(2'b01, 4, 3);
    wait_ready();
    check(tck_cnt - t0 == 10, "R4", "ir tck cycles", tck_cnt - t0, 10);
    check(upd_ir_cnt - u0 == 1 && tap_st == RTI, "R4", "single ir update", upd_ir_cnt - u0, 1);
    check(ir_upd == 4'b1000, "R4", "ir value", ir_upd, 4'b1000);
    host_read(0, v);
    check(v == 8'h05, "R6", "ir returned byte", v, 8'h05);

    // R5/R6 boundary lengths, then random
    run_dr(1, 1);
    run_dr(8, 2);
    run_dr(9, 3);
    run_dr(24, 2);
    for (int k = 0; k < 12; k++) run_dr(1 + int'($urandom % 40), 1 + int'($urandom % 4));

    // R10: empty starts
    t0 = tck_cnt;
    launch(2'b10, 0, 2);
    repeat (10) @(negedge clk);
    launch(2'b01, 0, 1);
    repeat (10) @(negedge clk);
    launch(2'b10, 12, 0);
    repeat (10) @(negedge clk);
    launch(2'b11, 12, 1);
    repeat (10) @(negedge clk);
    check(tck_cnt == t0 && ready === 1'b1, "R10", "empty starts tck cycles", tck_cnt - t0, 0);

    // R9 and R11: start and host write in mid scan
    for (int i = 0; i < 10; i++) begin img[i] = 8'($urandom); host_write(i, img[i]); end
    host_write(200, 8'h33);
    t0 = tck_cnt; u0 = upd_dr_cnt;
    launch(2'b10, 40, 2);
    repeat (20) @(negedge clk);
    host_write(200, 8'h5A);
    repeat (10) @(negedge clk);
    launch(2'b00, 0, 0);
    wait_ready();
    check(tck_cnt - t0 == 90 && upd_dr_cnt - u0 == 2, "R9", "busy start ignored",
          tck_cnt - t0, 90);
    host_read(200, v);
    check(v == 8'h33, "R11", "busy host write ignored", v, 8'h33);
    host_read(4, v);
    check(v == exp_byte(0, 40, 4), "R6", "mid-scan run byte", v, exp_byte(0, 40, 4));

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule